// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This unit sits in the execute stage of a small 16-bit load/store processor. It runs the three operate instructions (add, bitwise AND and bitwise complement) and holds the three condition flags N, Z and P that later conditional branches test. Each cycle it receives the instruction word, the two register operands that the register file has already read for it, and a strobe that marks the instruction as live. It also receives a value that other instruction classes computed or fetched: the memory word for the loads, or the address for the effective-address load.

The unit produces the value to write back, the destination register index and a write strobe. The register file outside the unit performs the write. Any value that goes to a register also goes into the flag register on the same clock edge, so the next instruction sees the new flags. Operate encodings with nonzero reserved bits raise an illegal-encoding output, and the unit then writes nothing.

Top module: `opu_top`

## Requirements
- R1: The opcode is instr_i[15:12]. Add is 0001, AND is 0101 and complement is 1001. For each of them dest_o equals instr_i[11:9]. When instr_i[5] is 0, add writes src_a_i + src_b_i, where src_a_i holds the register named by bits [8:6] and src_b_i holds the register named by bits [2:0].
- R2: When instr_i[5] is 1, the second operand of add and AND is instr_i[4:0] sign-extended to 16 bits, and src_b_i has no effect. Bits [4:3] may then take any value.
- R3: Add wraps modulo 2^16. No carry or overflow is reported.
- R4: AND writes the bitwise AND of src_a_i with the second operand, in both register mode and immediate mode.
- R5: Complement writes ~src_a_i.
- R6: flags_o is {N,Z,P} with N in bit 2, Z in bit 1 and P in bit 0, and exactly one of them is set. On the clock edge at which reg_we_o is high, the flags take N when result_o[15] is 1, Z when result_o is 0, and P otherwise. Before that edge the flags keep their old value.
- R7: Direct load (0010), indirect load (1010), base+offset load (0110) and effective-address load (1110) assert reg_we_o. They set result_o to ext_val_i and dest_o to instr_i[11:9], and they update the flags.
- R8: All other opcodes, for example store 0011, branch 0000 and subroutine call 0100, keep reg_we_o low and leave the flags unchanged.
- R9: In each of these cases illegal_o goes high, reg_we_o stays low and the flags stay unchanged:
  - add or AND with instr_i[5]=0 and instr_i[4:3] not 00;
  - complement with instr_i[5:0] not 111111.
- R10: A synchronous active-high reset sets the flags to Z (010), even when a write is requested in the same cycle.
- R11: While exec_i is low, reg_we_o and illegal_o stay low and the flags do not change, whatever the instruction word is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Instruction in this cycle is live |
| instr_i | input | 16 | Instruction word |
| src_a_i | input | 16 | Register named by instr_i[8:6] |
| src_b_i | input | 16 | Register named by instr_i[2:0] |
| ext_val_i | input | 16 | Loaded or computed value for load-class opcodes |
| result_o | output | 16 | Value to write to the destination register |
| dest_o | output | 3 | Destination register index |
| reg_we_o | output | 1 | Register write strobe |
| illegal_o | output | 1 | Operate encoding with nonzero reserved bits |
| flags_o | output | 3 | Registered {N,Z,P} |

## Verification
The operate instructions are driven with patterns that separate the two operand sources. In immediate mode the register operand is set to a value that would give a different sum, and for the loads the ALU inputs are nonzero, so a wrong operand choice or a wrong source selection changes the result. Sums are chosen so that each one lands on a positive, zero or negative result, including a wrap from 0xFFFF to zero and a crossing from 0x7FFx into the negative range. Together these tell apart the three flag encodings and a missing wrap. Stores, branches, calls, illegal encodings and an idle strobe are each issued after the flags hold P, with operands that would have produced Z or N. Any leak of a write therefore shows up as a flag change.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int WORD_W = 16;
    localparam int RIDX_W = 3;
    localparam int IMM_W  = 5;
    localparam int OPC_W  = 4;
    localparam int OPC_LSB = WORD_W - OPC_W;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LD  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_LDI = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_INV  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } cc_t;

    localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    typedef struct packed {
        alu_op_e             op;
        logic                use_imm;
        logic [WORD_W-1:0]   imm;
        logic [RIDX_W-1:0]   dest;
        logic                writes;
        logic                illegal;
    } dec_t;

    function automatic cc_t cc_of(input logic [WORD_W-1:0] v);
        cc_t c;
        c.n = v[WORD_W-1];
        c.z = (v == '0);
        c.p = !v[WORD_W-1] && (v != '0);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] f);
        return {{(WORD_W-IMM_W){f[IMM_W-1]}}, f};
    endfunction

endpackage

// File: rtl/opu_decode.sv
module opu_decode
    import opu_pkg::*;
(
    input  logic              exec_i,
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o
);
    localparam int DEST_LSB = OPC_LSB - RIDX_W;
    localparam int MODE_BIT = IMM_W;

    logic [OPC_W-1:0] opc;
    logic is_add, is_and, is_not, is_load;
    logic rsvd_bad;

    assign opc = instr_i[WORD_W-1:OPC_LSB];

    always_comb begin
        is_add  = (opc == OPC_ADD);
        is_and  = (opc == OPC_AND);
        is_not  = (opc == OPC_NOT);
        is_load = (opc == OPC_LD) || (opc == OPC_LDI) ||
                  (opc == OPC_LDR) || (opc == OPC_LEA);

        rsvd_bad = 1'b0;
        if ((is_add || is_and) && !instr_i[MODE_BIT])
            rsvd_bad = (instr_i[MODE_BIT-1:RIDX_W] != '0);
        else if (is_not)
            rsvd_bad = (instr_i[MODE_BIT:0] != '1);

        dec_o.op = ALU_PASS;
        if (is_add)      dec_o.op = ALU_ADD;
        else if (is_and) dec_o.op = ALU_AND;
        else if (is_not) dec_o.op = ALU_INV;

        dec_o.use_imm = instr_i[MODE_BIT];
        dec_o.imm     = sext_imm(instr_i[IMM_W-1:0]);
        dec_o.dest    = instr_i[OPC_LSB-1:DEST_LSB];
        dec_o.illegal = exec_i && rsvd_bad;
        dec_o.writes  = exec_i && (is_add || is_and || is_not || is_load) && !rsvd_bad;
    end
endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
(
    input  dec_t              dec_i,
    input  logic [WORD_W-1:0] src_a_i,
    input  logic [WORD_W-1:0] src_b_i,
    input  logic [WORD_W-1:0] ext_val_i,
    output logic [WORD_W-1:0] result_o
);
    logic [WORD_W-1:0] opnd_b;

    always_comb begin
        opnd_b = dec_i.use_imm ? dec_i.imm : src_b_i;
        unique case (dec_i.op)
            ALU_ADD: result_o = src_a_i + opnd_b;
            ALU_AND: result_o = src_a_i & opnd_b;
            ALU_INV: result_o = ~src_a_i;
            default: result_o = ext_val_i;
        endcase
    end
endmodule

// File: rtl/opu_cc_reg.sv
module opu_cc_reg
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [WORD_W-1:0] value_i,
    output cc_t               cc_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cc_o <= CC_RESET;
        else if (we_i)
            cc_o <= cc_of(value_i);
    end
endmodule

// File: rtl/opu_top.sv
module opu_top
    import opu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] src_a_i,
    input  logic [WORD_W-1:0] src_b_i,
    input  logic [WORD_W-1:0] ext_val_i,
    output logic [WORD_W-1:0] result_o,
    output logic [RIDX_W-1:0] dest_o,
    output logic              reg_we_o,
    output logic              illegal_o,
    output logic [2:0]        flags_o
);
    dec_t dec;
    cc_t  cc;

    opu_decode u_dec (
        .exec_i  (exec_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    opu_alu u_alu (
        .dec_i     (dec),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .ext_val_i (ext_val_i),
        .result_o  (result_o)
    );

    opu_cc_reg u_cc (
        .clk     (clk),
        .rst     (rst),
        .we_i    (dec.writes),
        .value_i (result_o),
        .cc_o    (cc)
    );

    assign dest_o    = dec.dest;
    assign reg_we_o  = dec.writes;
    assign illegal_o = dec.illegal;
    assign flags_o   = cc;
endmodule

// File: rtl/opu_chk.sv
module opu_chk
    import opu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec_i,
    input logic [WORD_W-1:0] instr_i,
    input logic [WORD_W-1:0] src_a_i,
    input logic [WORD_W-1:0] result_o,
    input logic              reg_we_o,
    input logic              illegal_o,
    input logic [2:0]        flags_o
);
    // R10
    reset_flags_z_chk: assert property (@(posedge clk)
        rst |=> flags_o == 3'b010);

    // R6
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(flags_o) == 1);

    // R6
    flags_follow_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> flags_o == {$past(result_o[WORD_W-1]),
                                 $past(result_o) == '0,
                                 !$past(result_o[WORD_W-1]) && $past(result_o) != '0});

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we_o |=> $stable(flags_o));

    // R9
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !reg_we_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_i |-> !reg_we_o && !illegal_o);

    // R5
    invert_result_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && instr_i[WORD_W-1:OPC_LSB] == OPC_NOT && !illegal_o) |-> result_o == ~src_a_i);
endmodule

bind opu_top opu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .exec_i    (exec_i),
    .instr_i   (instr_i),
    .src_a_i   (src_a_i),
    .result_o  (result_o),
    .reg_we_o  (reg_we_o),
    .illegal_o (illegal_o),
    .flags_o   (flags_o)
);

// File: tb/opu_top_bench.sv
module opu_top_bench;
    localparam int NV = 21;
    localparam logic [2:0] FN = 3'b100, FZ = 3'b010, FP = 3'b001;

    // {exec, instr, src_a, src_b, ext, exp_result, exp_we, exp_ill, exp_flags_after, req}
    localparam logic [89:0] VECS [NV] = '{
        {1'b1, 16'h14C4, 16'h0005, 16'h0003, 16'h5555, 16'h0008, 1'b1, 1'b0, FP, 4'd1},  // R1 add reg
        {1'b1, 16'h127F, 16'h0001, 16'h1234, 16'h5555, 16'h0000, 1'b1, 1'b0, FZ, 4'd2},  // R2 imm -1
        {1'b1, 16'h102F, 16'h7FF5, 16'h0001, 16'h5555, 16'h8004, 1'b1, 1'b0, FN, 4'd2},  // R2 imm +15
        {1'b1, 16'h14C4, 16'hFFFF, 16'h0001, 16'h5555, 16'h0000, 1'b1, 1'b0, FZ, 4'd3},  // R3 wrap
        {1'b1, 16'h5705, 16'hF0F0, 16'h0FFF, 16'h5555, 16'h00F0, 1'b1, 1'b0, FP, 4'd4},  // R4 and reg
        {1'b1, 16'h5BB0, 16'h8ABC, 16'h0000, 16'h5555, 16'h8AB0, 1'b1, 1'b0, FN, 4'd4},  // R4 and imm -16
        {1'b1, 16'h5020, 16'hFFFF, 16'hFFFF, 16'h5555, 16'h0000, 1'b1, 1'b0, FZ, 4'd4},  // R4 and imm 0
        {1'b1, 16'h9CBF, 16'h00FF, 16'h0000, 16'h5555, 16'hFF00, 1'b1, 1'b0, FN, 4'd5},  // R5 not
        {1'b1, 16'h9CBF, 16'hFFFF, 16'h0000, 16'h5555, 16'h0000, 1'b1, 1'b0, FZ, 4'd5},  // R5 not to zero
        {1'b1, 16'h2905, 16'h1111, 16'h2222, 16'h7000, 16'h7000, 1'b1, 1'b0, FP, 4'd7},  // R7 direct load
        {1'b1, 16'hAE00, 16'h1111, 16'h2222, 16'h8000, 16'h8000, 1'b1, 1'b0, FN, 4'd7},  // R7 indirect load
        {1'b1, 16'h6240, 16'h1111, 16'h2222, 16'h0000, 16'h0000, 1'b1, 1'b0, FZ, 4'd7},  // R7 base load
        {1'b1, 16'hE4AB, 16'h1111, 16'h2222, 16'h3FC8, 16'h3FC8, 1'b1, 1'b0, FP, 4'd7},  // R7 address load
        {1'b1, 16'h3A00, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, FP, 4'd8},  // R8 store
        {1'b1, 16'h0E05, 16'h0000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b0, FP, 4'd8},  // R8 branch
        {1'b1, 16'h4800, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, FP, 4'd8},  // R8 call
        {1'b1, 16'h1008, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, FP, 4'd9},  // R9 add rsvd
        {1'b1, 16'h5010, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, FP, 4'd9},  // R9 and rsvd
        {1'b1, 16'h9CBE, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1, FP, 4'd9},  // R9 not rsvd
        {1'b0, 16'h1008, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, FP, 4'd11}, // R11 idle
        {1'b1, 16'h1E07, 16'h1234, 16'h8000, 16'h5555, 16'h9234, 1'b1, 1'b0, FN, 4'd1}   // R1 dest 7
    };

    logic clk = 1'b0;
    logic rst;
    logic exec_i;
    logic [15:0] instr_i, src_a_i, src_b_i, ext_val_i;
    logic [15:0] result_o;
    logic [2:0]  dest_o;
    logic        reg_we_o, illegal_o;
    logic [2:0]  flags_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opu_top u_opu_top (
        .clk       (clk),
        .rst       (rst),
        .exec_i    (exec_i),
        .instr_i   (instr_i),
        .src_a_i   (src_a_i),
        .src_b_i   (src_b_i),
        .ext_val_i (ext_val_i),
        .result_o  (result_o),
        .dest_o    (dest_o),
        .reg_we_o  (reg_we_o),
        .illegal_o (illegal_o),
        .flags_o   (flags_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ex, input logic [15:0] ins, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] e);
        exec_i = ex; instr_i = ins; src_a_i = a; src_b_i = b; ext_val_i = e;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<5000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0] prev;
        rst = 1'b1;
        drive(1'b0, 16'h0000, 16'h0, 16'h0, 16'h0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        chk(flags_o == FZ, "R10", "reset flags", {13'b0, flags_o}, {13'b0, FZ});
        // R11 idle outputs
        chk(!reg_we_o && !illegal_o, "R11", "idle we/ill", {14'b0, reg_we_o, illegal_o}, 16'h0);
        prev = FZ;

        for (int i = 0; i < NV; i++) begin
            logic [89:0] v;
            string rq;
            v = VECS[i];
            rq = $sformatf("R%0d", v[3:0]);
            @(negedge clk);
            drive(v[89], v[88:73], v[72:57], v[56:41], v[40:25]);
            #1;
            chk(reg_we_o == v[8], rq, "reg_we", {15'b0, reg_we_o}, {15'b0, v[8]});
            chk(illegal_o == v[7], rq, "illegal", {15'b0, illegal_o}, {15'b0, v[7]});
            if (v[8]) begin
                chk(result_o == v[24:9], rq, "result", result_o, v[24:9]);
                chk(dest_o == v[84:82], rq, "dest", {13'b0, dest_o}, {13'b0, v[84:82]});
            end
            // R6 old flags still visible before the edge
            chk(flags_o == prev, "R6", "flags before edge", {13'b0, flags_o}, {13'b0, prev});
            @(posedge clk);
            #2;
            chk(flags_o == v[6:4], rq, "flags after edge", {13'b0, flags_o}, {13'b0, v[6:4]});
            prev = v[6:4];
        end

        // R10 reset beats a write that would set P
        @(negedge clk);
        drive(1'b1, 16'h14C4, 16'h0001, 16'h0001, 16'h0);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk(flags_o == FZ, "R10", "reset over write", {13'b0, flags_o}, {13'b0, FZ});
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 16'h9CBF, 16'h0000, 16'h0000, 16'h0);
        @(posedge clk);
        #2;
        // R5 and R6: complement of zero is all ones, negative
        chk(flags_o == FN, "R5", "not zero flags", {13'b0, flags_o}, {13'b0, FN});
        @(negedge clk);
        drive(1'b0, 16'h9CBF, 16'h8000, 16'h0, 16'h0);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk(flags_o == FZ, "R10", "mid-run reset", {13'b0, flags_o}, {13'b0, FZ});
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule